// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters on a single data line. A one-cycle receive-clock enable, `rx_tick`, is supplied from outside. The block samples the line once per tick (x1) or oversamples it 16 or 64 times per bit. It finds the start bit and collects a character of 5 to 8 data bits, least significant first. It then takes an optional parity bit and checks the stop bit.

The finished character goes into a data register and raises a ready flag. A read strobe clears that flag. Parity, framing and overrun errors collect in a status byte and stay set until software writes a command byte with the error-reset bit.

The frame format comes from a mode byte and is decoded from these fields:

| Field | Bits | Encoding |
|---|---|---|
| Clock factor | [1:0] | 01 = x1, 10 = x16, 11 = x64, 00 = receiver held idle |
| Character length | [3:2] | 5 + value |
| Parity enable | [4] | 1 = parity bit present |
| Parity sense | [5] | 1 = even, 0 = odd |

The receiver ignores mode bits [7:6]; it checks only the first stop bit.

Top module: `serial_rx`

## Requirements
- R1: After reset, `status` and `rx_data` are both zero.
- R2: The character length is 5 + `mode_cfg[3:2]`, and data bits arrive least significant first. The character sits right-justified in `rx_data`, and the unused upper bits read zero.
- R3: `status[1]` (ready) goes high on the clock edge that samples the stop bit. A one-cycle `data_rd` pulse clears it.
- R4: When `mode_cfg[4]` is 1, `status[3]` (parity error) sets if the data bits plus the parity bit hold an odd number of ones under even sense (`mode_cfg[5]`=1), or an even number under odd sense. When `mode_cfg[4]` is 0, no parity bit is expected and `status[3]` never sets.
- R5: `status[5]` (framing error) sets when the stop bit is sampled low.
- R6: `status[4]` (overrun) sets when a character completes while ready is still high. The new character replaces the old one in `rx_data`.
- R7: The three error flags are sticky. Only a `cmd_wr` with `cmd_wdata[4]`=1 clears them.
- R8: The last `cmd_wr` sets the receive enable to `cmd_wdata[2]`. While that enable is 0, nothing is received.
- R9: In x16 and x64 modes, the line must still be low half a bit after a falling edge, or the edge is ignored. With `mode_cfg[1:0]`=00, nothing is received.
- R10: In x1 mode, every `rx_tick` samples one bit. A low level seen while idle starts a frame.
- R11: Status bits 7, 6, 2 and 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | Receive-clock enable, one cycle per tick |
| rxd | input | 1 | Serial data line, idles high |
| mode_cfg | input | 8 | Frame format (factor, length, parity) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte: bit 2 enable, bit 4 error reset |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Received character |
| status | output | 8 | {0,0,framing,overrun,parity,0,ready,0} |

## Verification
The line passes through two synchronizer flops, so a level on `rxd` reaches the sampler two clocks after it is driven. The bench therefore changes `rxd` only on the tick cycle. Each result then lands on the clock edge of the mid-stop-bit sample: in x1 that is the stop tick, and in oversampled modes it is half a bit into the stop bit. The bench holds the line idle for two more bit times before it compares `status` and `rx_data`, so every result is long settled. Effects of a read or command strobe are due one clock after the strobe and are sampled on the following falling edge.

// File: rtl/serial_rx.sv
module serial_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rxd,
  input  logic [7:0] mode_cfg,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_wdata,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic [7:0] status
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} st_t;

  st_t        st;
  logic       rxd_m, rxd_s, rxd_q;
  logic [5:0] cnt;
  logic [3:0] idx;
  logic [7:0] shreg;
  logic       par_bit;
  logic       rx_en, rdy, pe, oe, fe;

  wire [1:0] fsel     = mode_cfg[1:0];
  wire       x1       = (fsel == 2'b01);
  wire       active   = rx_en && (fsel != 2'b00);
  wire [3:0] nbits    = 4'd5 + {2'b00, mode_cfg[3:2]};
  wire       pen      = mode_cfg[4];
  wire       even     = mode_cfg[5];
  wire [3:0] stop_idx = nbits + {3'b000, pen};
  wire [5:0] last_cnt = (fsel == 2'b11) ? 6'd63 : 6'd15;
  wire [5:0] half_cnt = (fsel == 2'b11) ? 6'd31 : 6'd7;
  wire       fall     = rxd_q & ~rxd_s;
  wire       samp     = (st == S_DATA) && rx_tick && (x1 || cnt == last_cnt);
  wire       stop_now = samp && (idx == stop_idx);
  wire       er       = cmd_wr & cmd_wdata[4];
  wire       perr     = pen & ~(^shreg ^ par_bit ^ even);

  assign status = {2'b00, fe, oe, pe, 1'b0, rdy, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rxd_m, rxd_s, rxd_q} <= 3'b111;
    else        {rxd_m, rxd_s, rxd_q} <= {rxd, rxd_m, rxd_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rx_en <= 1'b0;
    else if (cmd_wr) rx_en <= cmd_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (x1) begin
            if (rx_tick && !rxd_s) begin
              st    <= S_DATA;
              shreg <= '0;
            end
          end else if (fall) begin
            st <= S_START;
          end
        end
        S_START: if (rx_tick) begin
          if (cnt == half_cnt) begin
            cnt <= '0;
            if (!rxd_s) begin
              st    <= S_DATA;
              shreg <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        S_DATA: if (rx_tick) begin
          if (samp) begin
            cnt <= '0;
            idx <= idx + 4'd1;
            if (idx < nbits)                     shreg[idx[2:0]] <= rxd_s;
            else if (pen && idx == nbits)        par_bit <= rxd_s;
            if (stop_now)                        st <= S_IDLE;
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (!active) st <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rdy     <= 1'b0;
      pe      <= 1'b0;
      oe      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (stop_now) rx_data <= shreg;
      rdy <= stop_now | (rdy & ~data_rd);
      oe  <= (oe & ~er) | (stop_now & rdy & ~data_rd);
      pe  <= (pe & ~er) | (stop_now & perr);
      fe  <= (fe & ~er) | (stop_now & ~rxd_s);
    end
  end

  p_rdy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> status[1]);
  p_rdy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !stop_now |=> !status[1]);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now && status[1] && !data_rd |=> status[4]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !er |=> (status[5:3] & $past(status[5:3])) == $past(status[5:3]));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    er && !stop_now |=> status[5:3] == 3'b000);
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> st == S_IDLE);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_now |=> $stable(rx_data));
endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, cmd_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] mode_cfg = 8'h0E, cmd_wdata = 8'h00;
  logic [7:0] rx_data, status;
  logic [1:0] tcnt = 2'd0;
  wire  rx_tick = (tcnt == 2'd3);
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tcnt <= tcnt + 2'd1;

  serial_rx u_serial_rx (.clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd),
    .mode_cfg(mode_cfg), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .data_rd(data_rd),
    .rx_data(rx_data), .status(status));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!rx_tick) @(negedge clk);
  endtask

  function automatic int fac_of(logic [1:0] f);
    return (f == 2'b01) ? 1 : (f == 2'b10) ? 16 : 64;
  endfunction

  function automatic logic par_of(logic [7:0] d, int n, logic even);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p ^= d[i];
    return even ? p : ~p;
  endfunction

  task automatic line_bit(logic v, int fac);
    rxd = v;
    repeat (fac) wait_tick();
  endtask

  task automatic send(logic [7:0] d, logic perr, logic stopv);
    int fac = fac_of(mode_cfg[1:0]);
    int n = 5 + mode_cfg[3:2];
    wait_tick();
    line_bit(1'b0, fac);
    for (int i = 0; i < n; i++) line_bit(d[i], fac);
    if (mode_cfg[4]) line_bit(par_of(d, n, mode_cfg[5]) ^ perr, fac);
    line_bit(stopv, fac);
    line_bit(1'b1, 2 * fac);
  endtask

  task automatic cmd(logic [7:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    done();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 data", rx_data, 8'h00);
    rst_n = 1'b1;
    cmd(8'h04);

    for (int i = 0; i < 24; i++) begin
      logic [1:0] fs = ($urandom % 4 == 0) ? 2'b11 : (($urandom % 2) ? 2'b01 : 2'b10);
      logic [1:0] ln = 2'($urandom % 4);
      logic pen = 1'($urandom % 2), ev = 1'($urandom % 2);
      logic perr = 1'($urandom % 3 == 0), sb = ($urandom % 5 == 0);
      int n = 5 + ln;
      logic [7:0] d = 8'($urandom) & 8'((1 << n) - 1);
      logic [7:0] dn = 8'($urandom) | 8'hE0;
      rd(); cmd(8'h14);
      mode_cfg = {2'b00, ev, pen, ln, fs};
      send(dn & 8'((1 << n) - 1) | d, perr, ~sb);
      check($sformatf("R2 R10 data mode=%h", mode_cfg), rx_data, (dn & 8'((1 << n) - 1)) | d);
      check("R3 R4 R5 R11 status", status,
            {2'b00, sb, 1'b0, pen & perr, 1'b0, 1'b1, 1'b0});
    end

    mode_cfg = 8'h0E;
    rd(); cmd(8'h14);
    check("R3 ready cleared by read", status, 8'h00);

    send(8'hA5, 1'b0, 1'b1);
    send(8'h3C, 1'b0, 1'b1);
    check("R6 overrun status", status, 8'h12);
    check("R6 newest data kept", rx_data, 8'h3C);

    rd();
    mode_cfg = 8'h1E;
    send(8'h81, 1'b1, 1'b1);
    rd();
    send(8'h42, 1'b0, 1'b1);
    check("R7 flags sticky across good frame", status, 8'h1A);
    cmd(8'h04);
    check("R7 enable rewrite leaves flags", status, 8'h1A);
    cmd(8'h14);
    check("R7 error reset", status, 8'h02);

    rd();
    mode_cfg = 8'h0E;
    cmd(8'h10);
    send(8'h55, 1'b0, 1'b1);
    check("R8 disabled receives nothing", status, 8'h00);
    cmd(8'h04);

    wait_tick();
    line_bit(1'b0, 3);
    line_bit(1'b1, 48);
    check("R9 short low pulse ignored", status, 8'h00);
    send(8'h99, 1'b0, 1'b1);
    check("R9 frame after glitch data", rx_data, 8'h99);

    rd();
    mode_cfg = 8'h0C;
    send(8'h66, 1'b0, 1'b1);
    check("R9 factor 00 receives nothing", status, 8'h00);

    mode_cfg = 8'h01;
    send(8'h1F, 1'b0, 1'b0);
    check("R10 R5 x1 length 5 framing", status, 8'h22);
    check("R2 x1 length 5 data", rx_data, 8'h1F);

    done();
  end
endmodule